// File: doc/BRIEF.md
# Byte Mailbox with Transmit and Receive FIFOs

This block is a two-way byte channel between a processor and an outside host. The processor reaches it through an AXI4-Lite slave that decodes four word-aligned registers. Writing the transmit data register queues a byte toward the host. Reading the receive data register takes the oldest byte the host has sent. Two status registers report, for each direction, how many bytes are waiting and whether that queue is full or empty.

On the host side each direction is a plain byte stream with a valid/ready handshake. The transmit stream offers the oldest queued byte whenever its queue holds anything. The receive stream takes bytes while its queue has room. Each queue is a 16-entry FIFO. Its occupancy count moves on the same clock edge as the push or pop that changes it, including when a push and a pop land on the same edge.

Top module: `byte_mailbox`

## Requirements
- R1: A bus write to offset 0x00 pushes bits 7:0 of the write data into the transmit FIFO, and bytes leave on `tx_data` in the order they were written.
- R2: A bus write to offset 0x00 while the transmit FIFO holds 16 bytes is discarded, leaves the contents and count unchanged, and still completes with response OKAY (2'b00).
- R3: A bus read of offset 0x08 returns the oldest receive byte in bits 7:0 with bits 31:8 zero, and removes that byte. A read while the receive FIFO is empty returns 0 and removes nothing.
- R4: Offsets 0x04 (transmit) and 0x0C (receive) read as a status word: occupancy in bits 31:16, bit 8 set exactly when that FIFO holds 16 bytes, bit 0 set exactly when it holds none, and every other bit zero.
- R5: Each FIFO holds 16 bytes. When a push and a pop of the same FIFO happen on the same edge, the count is unchanged and both bytes take effect in order.
- R6: Writes to 0x04, 0x08, 0x0C, to any offset other than the four listed, or to any address with bits 1:0 nonzero, change nothing and respond OKAY. Reads of such unmapped addresses return 0 with OKAY.
- R7: `tx_valid` is high exactly while the transmit FIFO is non-empty. A byte is removed on each edge where `tx_valid` and `tx_ready` are both high, and `tx_data` holds steady while the byte waits.
- R8: `rx_ready` is low exactly while the receive FIFO is full. A byte is stored on each edge where `rx_valid` and `rx_ready` are both high.
- R9: A synchronous active-low `rst_n` empties both FIFOs, so both status words read 0x00000001 afterwards.
- R10: Once `s_bvalid` or `s_rvalid` is raised, it stays high with stable response and data until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| tx_data | output | 8 | Byte offered to the host |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Host takes the transmit byte |
| rx_data | input | 8 | Byte offered by the host |
| rx_valid | input | 1 | Receive byte available |
| rx_ready | output | 1 | Block can store a receive byte |

## Verification
A push and a pop of the same FIFO can fall on one edge. For transmit, a bus write handshake meets a host `tx_ready`. For receive, a host `rx_valid` meets a bus read of the receive data register. The bench lines both up on a single edge. It then reads the status word to confirm the count did not move, and drains the FIFO to confirm that the departing byte was the old head and that the arriving byte took its place at the tail. A second case reads the full receive FIFO and checks that `rx_ready` rises on the very next cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam logic [15:0] OFS_TX_DATA = 16'h0000;
  localparam logic [15:0] OFS_TX_STAT = 16'h0004;
  localparam logic [15:0] OFS_RX_DATA = 16'h0008;
  localparam logic [15:0] OFS_RX_STAT = 16'h000C;
  localparam logic [1:0]  RESP_OKAY   = 2'b00;

  typedef enum logic [2:0] {
    SEL_TXD,
    SEL_TXS,
    SEL_RXD,
    SEL_RXS,
    SEL_NONE
  } reg_sel_e;

  // Address decode: anything not exactly one of the four offsets is unmapped.
  function automatic reg_sel_e decode_ofs(input logic [15:0] addr);
    reg_sel_e s;
    case (addr)
      OFS_TX_DATA: s = SEL_TXD;
      OFS_TX_STAT: s = SEL_TXS;
      OFS_RX_DATA: s = SEL_RXD;
      OFS_RX_STAT: s = SEL_RXS;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

  // Status word packing: occupancy high half, full at bit 8, empty at bit 0.
  function automatic logic [31:0] status_word(input logic [15:0] cnt,
                                              input logic full,
                                              input logic empty);
    return {cnt, 7'b0, full, 7'b0, empty};
  endfunction

  // Occupancy after one edge with the given accepted push/pop events.
  function automatic int unsigned count_step(input int unsigned cnt,
                                             input logic push,
                                             input logic pop);
    return cnt + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             push_done,
  output logic             pop_done
);
  import mbx_pkg::*;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign push_done = push && !full;
  assign pop_done  = pop && !empty;
  assign dout      = mem[rptr_q];
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (push_done) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_done) wptr_q <= ptr_inc(wptr_q);
      if (pop_done)  rptr_q <= ptr_inc(rptr_q);
      cnt_q <= CNT_W'(count_step(int'(cnt_q), push_done, pop_done));
    end
  end

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, empty}));

  // R2
  drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt_q) && full);

  // R3
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty && $stable(rptr_q));

endmodule

// File: rtl/mbx_axil_regs.sv
module mbx_axil_regs #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              tx_push,
  output logic [7:0]        tx_push_data,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              tx_full,
  input  logic              tx_empty,
  output logic              rx_pop,
  input  logic [7:0]        rx_head,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_full,
  input  logic              rx_empty
);
  import mbx_pkg::*;

  logic        bvalid_q, rvalid_q;
  logic [31:0] rdata_q;
  logic        wr_hs, rd_hs;
  reg_sel_e    wsel, rsel;
  logic [31:0] rd_mux;
  logic [23:0] wdata_unused;

  assign wdata_unused = s_wdata[31:8];

  assign wsel = decode_ofs(16'(s_awaddr));
  assign rsel = decode_ofs(16'(s_araddr));

  // Write channel: address and data taken together, one response in flight.
  assign s_awready = s_awvalid && s_wvalid && !bvalid_q;
  assign s_wready  = s_awready;
  assign wr_hs     = s_awready;

  assign s_arready = !rvalid_q;
  assign rd_hs     = s_arvalid && s_arready;

  assign tx_push      = wr_hs && (wsel == SEL_TXD);
  assign tx_push_data = s_wdata[7:0];
  assign rx_pop       = rd_hs && (rsel == SEL_RXD) && !rx_empty;

  always_comb begin
    case (rsel)
      SEL_TXS: rd_mux = status_word(16'(tx_count), tx_full, tx_empty);
      SEL_RXS: rd_mux = status_word(16'(rx_count), rx_full, rx_empty);
      SEL_RXD: rd_mux = rx_empty ? 32'h0 : {24'h0, rx_head};
      default: rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_hs)                      bvalid_q <= 1'b1;
      else if (bvalid_q && s_bready)  bvalid_q <= 1'b0;
      if (rd_hs) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_mux;
      end else if (rvalid_q && s_rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign s_bvalid = bvalid_q;
  assign s_bresp  = RESP_OKAY;
  assign s_rvalid = rvalid_q;
  assign s_rdata  = rdata_q;
  assign s_rresp  = RESP_OKAY;

  // R10
  bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> s_bvalid && $stable(s_bresp));

  // R10
  rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> s_rvalid && $stable(s_rdata));

  // R3
  rx_pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> s_arready && !rx_empty);

endmodule

// File: rtl/byte_mailbox.sv
module byte_mailbox #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready
);

  logic             tx_push, rx_pop;
  logic [7:0]       tx_push_data, rx_head;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_push_done, tx_pop_done, rx_push_done, rx_pop_done;

  mbx_axil_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_count(tx_count),
    .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_pop(rx_pop), .rx_head(rx_head), .rx_count(rx_count),
    .rx_full(rx_full), .rx_empty(rx_empty)
  );

  mbx_fifo #(.DEPTH(DEPTH), .W(8)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .din(tx_push_data),
    .pop(tx_ready), .dout(tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty),
    .push_done(tx_push_done), .pop_done(tx_pop_done)
  );

  mbx_fifo #(.DEPTH(DEPTH), .W(8)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid), .din(rx_data),
    .pop(rx_pop), .dout(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty),
    .push_done(rx_push_done), .pop_done(rx_pop_done)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data));

  // R8
  rx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_done |-> rx_valid && rx_ready);

  // R5
  tx_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_done && tx_pop_done) |=> $stable(tx_count));

  // R5
  rx_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push_done && rx_pop_done) |=> $stable(rx_count));

endmodule

// File: tb/byte_mailbox_tb.sv
`timescale 1ns/1ps
module byte_mailbox_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
  logic [31:0] s_wdata = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [7:0]  tx_data, rx_data = '0;
  logic        tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  byte_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  // Expected status word built from the requirement text.
  function automatic logic [31:0] exp_stat(input int n);
    logic [31:0] v;
    v = 32'(n) << 16;
    if (n == 16) v = v | 32'h100;
    if (n == 0)  v = v | 32'h1;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_awvalid = 1; s_wvalid = 1;
    @(posedge clk);
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    chk(req, {30'b0, s_bresp}, 32'h0);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    @(posedge clk);
    @(negedge clk);
    s_arvalid = 0;
    d = s_rdata;
  endtask

  task automatic host_push(input logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic host_pop(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(req, {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, exp});
    tx_ready = 1;
    @(posedge clk);
    @(negedge clk);
    tx_ready = 0;
  endtask

  // Vector table: {is_write, addr, wdata, expected read data}
  localparam int NV = 12;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h04, 32'h0,        32'h0000_0001},
    {1'b0, 8'h0C, 32'h0,        32'h0000_0001},
    {1'b1, 8'h00, 32'hDEAD_01A5, 32'h0},
    {1'b1, 8'h00, 32'h0000_003C, 32'h0},
    {1'b0, 8'h04, 32'h0,        32'h0002_0000},
    {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 8'h02, 32'h0000_0055, 32'h0},
    {1'b0, 8'h04, 32'h0,        32'h0002_0000},
    {1'b0, 8'h08, 32'h0,        32'h0},
    {1'b0, 8'h20, 32'h0,        32'h0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R9 reset state at the ports
    chk("R9 tx_valid", {31'b0, tx_valid}, 32'h0);
    chk("R9 rx_ready", {31'b0, rx_ready}, 32'h1);

    // Table walk: R1 R4 R6 R3
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) bus_wr(VEC[i][71:64], VEC[i][63:32], "R6 bresp");
      else begin
        bus_rd(VEC[i][71:64], rd);
        chk("R4/R6/R3 table read", rd, VEC[i][31:0]);
      end
    end
    bus_rd(8'h0C, rd); chk("R6 rx untouched", rd, exp_stat(0));

    // R5 tx: bus push and host pop on one edge
    @(negedge clk);
    chk("R7 head", {24'b0, tx_data}, 32'hA5);
    s_awaddr = 8'h00; s_wdata = 32'h77; s_awvalid = 1; s_wvalid = 1; tx_ready = 1;
    @(posedge clk);
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0; tx_ready = 0;
    bus_rd(8'h04, rd); chk("R5 tx count same", rd, exp_stat(2));
    host_pop(8'h3C, "R1 order");
    host_pop(8'h77, "R5 tx tail");
    @(negedge clk); chk("R7 tx_valid low", {31'b0, tx_valid}, 32'h0);

    // R2 fill tx to 16 then one more
    for (int i = 0; i < 17; i++) bus_wr(8'h00, 32'(i + 8'h40), "R2 bresp");
    bus_rd(8'h04, rd); chk("R2 tx full status", rd, exp_stat(16));
    for (int i = 0; i < 16; i++) host_pop(8'(i + 8'h40), "R2 contents");
    bus_rd(8'h04, rd); chk("R2 extra dropped", rd, exp_stat(0));

    // R8 fill rx
    for (int i = 0; i < 16; i++) host_push(8'(i + 8'h80));
    @(negedge clk); chk("R8 rx_ready low", {31'b0, rx_ready}, 32'h0);
    host_push(8'hEE);
    bus_rd(8'h0C, rd); chk("R8 full status", rd, exp_stat(16));
    bus_rd(8'h08, rd); chk("R3 oldest", rd, 32'h80);
    chk("R8 rx_ready back", {31'b0, rx_ready}, 32'h1);
    for (int i = 1; i < 16; i++) begin
      bus_rd(8'h08, rd); chk("R3 order", rd, 32'(i + 8'h80));
    end
    bus_rd(8'h08, rd); chk("R3 empty read", rd, 32'h0);
    bus_rd(8'h0C, rd); chk("R3 no pop", rd, exp_stat(0));

    // R5 rx: host push and bus read on one edge
    host_push(8'h11);
    @(negedge clk);
    s_araddr = 8'h08; s_arvalid = 1; rx_data = 8'h22; rx_valid = 1;
    @(posedge clk);
    @(negedge clk);
    s_arvalid = 0; rx_valid = 0;
    chk("R5 rx pop value", s_rdata, 32'h11);
    bus_rd(8'h0C, rd); chk("R5 rx count same", rd, exp_stat(1));
    bus_rd(8'h08, rd); chk("R5 rx tail", rd, 32'h22);

    // R10 response held while ready low
    s_rready = 0;
    @(negedge clk); s_araddr = 8'h04; s_arvalid = 1;
    @(posedge clk); @(negedge clk); s_arvalid = 0;
    @(posedge clk); @(negedge clk);
    chk("R10 rvalid held", {31'b0, s_rvalid}, 32'h1);
    s_rready = 1;
    @(posedge clk); @(negedge clk);
    chk("R10 rvalid drop", {31'b0, s_rvalid}, 32'h0);

    // R9 reset with data in both FIFOs
    bus_wr(8'h00, 32'h5, "R9 bresp");
    host_push(8'h6);
    @(negedge clk); rst_n = 0;
    @(posedge clk); @(negedge clk); rst_n = 1;
    bus_rd(8'h04, rd); chk("R9 tx status", rd, 32'h1);
    bus_rd(8'h0C, rd); chk("R9 rx status", rd, 32'h1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule